// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from up to 32 on-chip sources and merges them into one request line toward a host processor. Software programs it through a small register window. One register holds the global enable, the level at which the merged request is presented, the source promoted above all others and the routing of four channel sources into a group of priority slots. The other registers hold the per-source enable bits, the sampled request levels, the in-service bits and the acknowledge/vector port.

To take an interrupt, the host writes 1 to bit 0 of the vector register. The controller then records the highest-priority eligible source, sets that source's in-service bit, and shows the source number in bits 15:11 of the same register, where the host reads it back. When the handler is done, the host writes a 1 to the source's in-service bit to release it. A source that is in service holds off itself and every source of lower priority. A request can vanish between the raise of the merged line and the acknowledge, for example when software masks it. In that case the acknowledge returns vector 0, which is reserved as the error code, and software acknowledges it and carries on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. The addresses are configuration 0, pending 1, enable mask 2, in-service 3 and vector 4. Reads return data one cycle after `bus_rd_i`.
- R2: A source takes part only when its bit in the mask register (address 2) is 1. A source whose mask bit is 0 never raises `irq_o` and never wins an acknowledge.
- R3: `irq_o` is high exactly when configuration bit 0 (global enable) is 1 and at least one eligible source exists. It is a register, and it follows its inputs one cycle after they settle.
- R4: Writing a value with bit 0 set to address 4 is an acknowledge. A later read of address 4 shows the captured vector in bits 15:11, with all other bits 0. Writing to address 4 with bit 0 clear changes nothing.
- R5: Apart from the promoted source and the channel group, priority follows the source index, and a lower index wins.
- R6: The source named by configuration bits 17:13 beats every other eligible source.
- R7: A source whose in-service bit is set blocks itself and every source of lower priority. Sources of higher priority can still win.
- R8: An acknowledge with an eligible winner sets that source's in-service bit, which is readable at address 3.
- R9: Writing to address 3 clears each in-service bit written as 1. Bits written as 0 keep their value.
- R10: An acknowledge with no eligible source returns vector 0 and leaves the in-service bits unchanged. The request input of source 0 never has any effect.
- R11: Sources 4 to 7 form a channel group. Priority slot 4+g (g = 0..3) is held by channel 4 + (g XOR f_g), where f_g is the 2-bit field at configuration bits [5+2g:4+2g]. A value of 0 keeps the natural order.
- R12: `irq_level_o` shows configuration bits 3:1. The pending register (address 1) reads the request levels sampled one cycle earlier, and a request that goes low stops counting as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | 32 | Level request per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| irq_o | output | 1 | Merged request to the host |
| irq_level_o | output | 3 | Configured level of the merged request |

## Verification
The hardest situation to reach from the ports is the masking race: a source must raise `irq_o` and then lose its eligibility before the acknowledge, and the error vector must come back with no in-service side effect. The bench brings this about by enabling one source, waiting for `irq_o`, clearing its mask bit and only then acknowledging. In-service blocking under a remapped channel group with a promoted source is also hard to reach by hand. Random configurations, requests and partial in-service releases build up mixed in-service sets, and a bench model ranks every source to predict each vector.

// File: rtl/irq_vector_ctrl_pkg.sv
package irq_vector_ctrl_pkg;
  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_PEND = 3'd1,
    REG_MASK = 3'd2,
    REG_ISR  = 3'd3,
    REG_VEC  = 3'd4
  } reg_sel_e;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LVL_LSB = 1;
  localparam int CFG_LVL_W   = 3;
  localparam int CFG_GRP_LSB = 4;
  localparam int CFG_TOP_LSB = 13;
  localparam int VEC_MSB     = 15;
endpackage

// File: rtl/irq_vc_sampler.sv
module irq_vc_sampler #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_req_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= src_req_i;
  end
endmodule

// File: rtl/irq_vc_arbiter.sv
module irq_vc_arbiter #(
  parameter int N        = 32,
  parameter int VEC_W    = 5,
  parameter int GRP_BASE = 4,
  parameter int GRP_N    = 4,
  parameter int GW       = 2,
  parameter int ERR_VEC  = 0
) (
  input  logic [N-1:0]        act_i,
  input  logic [N-1:0]        isr_i,
  input  logic [VEC_W-1:0]    top_i,
  input  logic [GRP_N*GW-1:0] grp_i,
  output logic                found_o,
  output logic [VEC_W-1:0]    win_o
);
  localparam int ORD_N = N + 1;

  logic [VEC_W-1:0] slot_src [N];
  logic [VEC_W-1:0] ord_id   [ORD_N];
  logic [ORD_N-1:0] ord_req;
  logic [ORD_N-1:0] ord_isr;
  logic             blocked;

  for (genvar s = 0; s < N; s++) begin : g_slot
    if (s >= GRP_BASE && s < GRP_BASE + GRP_N) begin : g_grp
      localparam int G = s - GRP_BASE;
      assign slot_src[s] = VEC_W'(GRP_BASE + (G ^ int'(grp_i[G*GW +: GW])));
    end else begin : g_fix
      assign slot_src[s] = VEC_W'(s);
    end
  end

  assign ord_id[0]  = top_i;
  assign ord_req[0] = act_i[top_i];
  assign ord_isr[0] = isr_i[top_i];

  for (genvar s = 0; s < N; s++) begin : g_ord
    assign ord_id[s+1]  = slot_src[s];
    assign ord_req[s+1] = act_i[slot_src[s]] && (slot_src[s] != top_i);
    assign ord_isr[s+1] = isr_i[slot_src[s]] && (slot_src[s] != top_i);
  end

  always_comb begin
    blocked = 1'b0;
    found_o = 1'b0;
    win_o   = VEC_W'(ERR_VEC);
    for (int k = 0; k < ORD_N; k++) begin
      blocked = blocked | ord_isr[k];
      if (!found_o && !blocked && ord_req[k]) begin
        found_o = 1'b1;
        win_o   = ord_id[k];
      end
    end
  end
endmodule

// File: rtl/irq_vc_regs.sv
module irq_vc_regs
  import irq_vector_ctrl_pkg::*;
#(
  parameter int N       = 32,
  parameter int VEC_W   = 5,
  parameter int GRP_W   = 8,
  parameter int ERR_VEC = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [2:0]           addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [N-1:0]         pend_i,
  input  logic                 found_i,
  input  logic [VEC_W-1:0]     win_i,
  output logic                 en_o,
  output logic [CFG_LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0]     top_o,
  output logic [GRP_W-1:0]     grp_o,
  output logic [N-1:0]         mask_o,
  output logic [N-1:0]         isr_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [31:0]          rdata_o
);
  logic [31:0] cfg_q;

  assign en_o  = cfg_q[CFG_EN_BIT];
  assign lvl_o = cfg_q[CFG_LVL_LSB +: CFG_LVL_W];
  assign top_o = cfg_q[CFG_TOP_LSB +: VEC_W];
  assign grp_o = cfg_q[CFG_GRP_LSB +: GRP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      mask_o  <= '0;
      isr_o   <= '0;
      vec_o   <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_i) begin
        case (reg_sel_e'(addr_i))
          REG_CFG:  cfg_q  <= wdata_i;
          REG_MASK: mask_o <= wdata_i[N-1:0];
          REG_ISR:  isr_o  <= isr_o & ~wdata_i[N-1:0];
          REG_VEC: begin
            if (wdata_i[0]) begin
              vec_o <= found_i ? win_i : VEC_W'(ERR_VEC);
              if (found_i) isr_o[win_i] <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (rd_i) begin
        case (reg_sel_e'(addr_i))
          REG_CFG:  rdata_o <= cfg_q;
          REG_PEND: rdata_o <= 32'(pend_i);
          REG_MASK: rdata_o <= 32'(mask_o);
          REG_ISR:  rdata_o <= 32'(isr_o);
          REG_VEC:  rdata_o <= 32'(vec_o) << (VEC_MSB + 1 - VEC_W);
          default:  rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_ctrl_pkg::*;
#(
  parameter int N        = 32,
  parameter int GRP_BASE = 4,
  parameter int GRP_N    = 4,
  parameter int ERR_VEC  = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         src_req_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [2:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o,
  output logic [CFG_LVL_W-1:0] irq_level_o
);
  localparam int VEC_W = $clog2(N);
  localparam int GW    = (GRP_N > 1) ? $clog2(GRP_N) : 1;
  localparam int GRP_W = GRP_N * GW;
  localparam logic [N-1:0] SRC_OK = ~(N'(1) << ERR_VEC);

  logic [N-1:0]     pend_q, mask_q, isr_q, act;
  logic             cfg_en, arb_found;
  logic [VEC_W-1:0] cfg_top, arb_win, vec_q;
  logic [GRP_W-1:0] cfg_grp;

  irq_vc_sampler #(.N(N)) u_sampler (
    .clk(clk), .rst(rst), .src_req_i(src_req_i), .pend_o(pend_q)
  );

  assign act = pend_q & mask_q & SRC_OK;

  irq_vc_arbiter #(
    .N(N), .VEC_W(VEC_W), .GRP_BASE(GRP_BASE), .GRP_N(GRP_N),
    .GW(GW), .ERR_VEC(ERR_VEC)
  ) u_arb (
    .act_i(act), .isr_i(isr_q), .top_i(cfg_top), .grp_i(cfg_grp),
    .found_o(arb_found), .win_o(arb_win)
  );

  irq_vc_regs #(
    .N(N), .VEC_W(VEC_W), .GRP_W(GRP_W), .ERR_VEC(ERR_VEC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .pend_i(pend_q),
    .found_i(arb_found), .win_i(arb_win), .en_o(cfg_en),
    .lvl_o(irq_level_o), .top_o(cfg_top), .grp_o(cfg_grp),
    .mask_o(mask_q), .isr_o(isr_q), .vec_o(vec_q), .rdata_o(bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= cfg_en && arb_found;
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N       = 32,
  parameter int VEC_W   = 5,
  parameter int ERR_VEC = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr_i,
  input logic [2:0]       bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic             irq_o,
  input logic             cfg_en,
  input logic [VEC_W-1:0] cfg_top,
  input logic [N-1:0]     pend_q,
  input logic [N-1:0]     mask_q,
  input logic [N-1:0]     isr_q,
  input logic             arb_found,
  input logic [VEC_W-1:0] arb_win,
  input logic [VEC_W-1:0] vec_q
);
  logic ack;
  assign ack = bus_wr_i && (bus_addr_i == 3'd4) && bus_wdata_i[0];

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(cfg_en)); // R3
  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    arb_found |-> (mask_q[arb_win] && pend_q[arb_win])); // R2
  AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    arb_found |-> !isr_q[arb_win]); // R7
  AST_TOP_WINS: assert property (@(posedge clk) disable iff (rst)
    (mask_q[cfg_top] && pend_q[cfg_top] && !isr_q[cfg_top] && cfg_top != VEC_W'(ERR_VEC))
      |-> (arb_found && arb_win == cfg_top)); // R6
  AST_ISR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == 3'd3) |=> (isr_q == ($past(isr_q) & ~$past(bus_wdata_i[N-1:0])))); // R9
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    (ack && arb_found) |=> (isr_q[$past(arb_win)] && vec_q == $past(arb_win))); // R8
  AST_ERR_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (ack && !arb_found) |=> (vec_q == VEC_W'(ERR_VEC) && $stable(isr_q))); // R10
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .N(N), .VEC_W(VEC_W), .ERR_VEC(ERR_VEC)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .irq_o(irq_o), .cfg_en(cfg_en),
  .cfg_top(cfg_top), .pend_q(pend_q), .mask_q(mask_q), .isr_q(isr_q),
  .arb_found(arb_found), .arb_win(arb_win), .vec_q(vec_q)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_req = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [2:0]  irq_level;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst(rst), .src_req_i(src_req), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .irq_level_o(irq_level)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; src_req = '0;
    idle(3); rst = 1'b0; idle(1);
  endtask

  // Priority rank per requirements R5, R6, R11: smaller wins
  function automatic int rank_of(int c, logic [31:0] cfg);
    if (c == int'(cfg[17:13])) return 0;
    if (c >= 4 && c < 8) begin
      for (int g = 0; g < 4; g++)
        if (4 + (g ^ int'(cfg[4+2*g +: 2])) == c) return 5 + g;
      return 1000;
    end
    return 1 + c;
  endfunction

  // Expected winner per R2, R7, R10; -1 when none is eligible
  function automatic int model_win(logic [31:0] req, logic [31:0] msk, logic [31:0] isr, logic [31:0] cfg);
    int blk = 999, best = -1, br = 999;
    for (int c = 0; c < 32; c++)
      if (isr[c] && rank_of(c, cfg) < blk) blk = rank_of(c, cfg);
    for (int c = 1; c < 32; c++)
      if (req[c] && msk[c] && rank_of(c, cfg) < blk && rank_of(c, cfg) < br) begin
        br = rank_of(c, cfg); best = c;
      end
    return best;
  endfunction

  initial begin
    logic [31:0] d, cfg, msk, m_isr, clr;
    int w;
    void'($urandom(32'd2024));
    idle(3); rst = 1'b0; idle(1);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 register after reset", d, 0);
    end

    // R12 level output and pending register
    wr(3'd0, 32'h1 | (32'd5 << 1));
    idle(1);
    chk(irq_level == 3'd5, "R12 irq level", 32'(irq_level), 5);
    src_req = 32'hA5A5_0F0E; idle(2);
    rd(3'd1, d);
    chk(d == 32'hA5A5_0F0E, "R12 pending levels", d, 32'hA5A5_0F0E);

    // R2 mask gating
    idle(2);
    chk(irq == 1'b0, "R2 all masked", 32'(irq), 0);
    src_req = 32'h0000_0200; wr(3'd2, 32'h0000_0200); idle(2);
    chk(irq == 1'b1, "R2 unmasked source raises irq", 32'(irq), 1);

    // R3 global enable
    wr(3'd0, 32'h0); idle(2);
    chk(irq == 1'b0, "R3 disabled", 32'(irq), 0);
    wr(3'd0, 32'h1); idle(2);
    chk(irq == 1'b1, "R3 re-enabled", 32'(irq), 1);

    // R12 level-sensitive drop
    src_req = 32'h0; idle(3);
    chk(irq == 1'b0, "R12 request withdrawn", 32'(irq), 0);
    src_req = 32'h0000_0200; idle(3);

    // R4 ack with bit0 clear has no effect, then real ack
    wr(3'd4, 32'hFFFF_FFFE);
    rd(3'd4, d); chk(d == 0, "R4 no-ack write ignored", d, 0);
    rd(3'd3, d); chk(d == 0, "R4 no-ack leaves in-service", d, 0);
    wr(3'd4, 32'h1);
    rd(3'd4, d); chk(d == (32'd9 << 11), "R4 vector field", d, 32'd9 << 11);
    rd(3'd3, d); chk(d == 32'h200, "R8 in-service set", d, 32'h200);
    idle(1);
    chk(irq == 1'b0, "R7 in-service blocks itself", 32'(irq), 0);

    // R9 write-one-to-clear
    wr(3'd3, 32'h0);
    rd(3'd3, d); chk(d == 32'h200, "R9 zero write no effect", d, 32'h200);
    wr(3'd3, 32'h200);
    rd(3'd3, d); chk(d == 0, "R9 one clears", d, 0);

    // R10 masking race
    idle(2);
    chk(irq == 1'b1, "R10 raised before mask", 32'(irq), 1);
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h1);
    rd(3'd4, d); chk(d == 0, "R10 error vector", d, 0);
    rd(3'd3, d); chk(d == 0, "R10 no in-service on error", d, 0);
    src_req = 32'h1; wr(3'd2, 32'h1); idle(3);
    chk(irq == 1'b0, "R10 source 0 ignored", 32'(irq), 0);

    // R6 promoted source
    do_reset();
    src_req = 32'h0010_0008; wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1 | (32'd20 << 13)); idle(2);
    wr(3'd4, 32'h1); rd(3'd4, d);
    chk(d == (32'd20 << 11), "R6 promoted wins", d, 32'd20 << 11);

    // R5 plain order
    wr(3'd0, 32'h1); wr(3'd3, 32'hFFFF_FFFF); idle(1);
    wr(3'd4, 32'h1); rd(3'd4, d);
    chk(d == (32'd3 << 11), "R5 lower index wins", d, 32'd3 << 11);

    // R11 group remap and R7 blocking
    do_reset();
    src_req = 32'h0000_00A0; wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1 | (32'd3 << 4)); idle(2);
    wr(3'd4, 32'h1); rd(3'd4, d);
    chk(d == (32'd7 << 11), "R11 remapped channel wins", d, 32'd7 << 11);
    idle(1);
    chk(irq == 1'b0, "R7 lower sources blocked", 32'(irq), 0);
    src_req = 32'h0000_00A4; idle(3);
    chk(irq == 1'b1, "R7 higher source passes", 32'(irq), 1);
    wr(3'd4, 32'h1); rd(3'd4, d);
    chk(d == (32'd2 << 11), "R7 higher source vector", d, 32'd2 << 11);

    // Random mix (R3, R5, R6, R7, R8, R11)
    do_reset();
    m_isr = '0;
    for (int it = 0; it < 250; it++) begin
      src_req = $urandom;
      msk = $urandom | $urandom;
      cfg = ($urandom & 32'h0003_EFFE) | 32'h1;
      wr(3'd2, msk); wr(3'd0, cfg); idle(2);
      w = model_win(src_req, msk, m_isr, cfg);
      chk(irq == (w >= 0), "R3 random irq", 32'(irq), 32'(w >= 0));
      wr(3'd4, 32'h1); rd(3'd4, d);
      chk(d == ((w < 0) ? 32'h0 : (32'(w) << 11)), "R5 random vector", d,
          (w < 0) ? 32'h0 : (32'(w) << 11));
      if (w >= 0) m_isr[w] = 1'b1;
      rd(3'd3, d);
      chk(d == m_isr, "R8 random in-service", d, m_isr);
      clr = $urandom & $urandom;
      wr(3'd3, clr); m_isr &= ~clr;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule